// File: doc/BRIEF.md
# Serial Memory Address Pointer with Access-Dependent Wrap

This block keeps the single 16-bit current location register of a 64K x 8 serial memory. Reads and writes share it. The two address bytes of a write header load it in one strobe. After each byte is accessed it moves to the following location, so it always names the byte after the last one touched. A current address read uses that value directly.

How the register advances depends on the kind of access. A read advance counts through the whole array, crossing page boundaries and wrapping from the top location to zero. A write advance counts only within the low page bits, so a burst that passes the end of a 128-byte page returns to the start of the same page. In hardware the power-up content is undefined. A parameter chooses whether reset loads a fixed value or, as a simulation model, an unknown one.

Top module: `mem_addr_ptr`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with no strobe, `cur_addr` equals `RST_VAL` (default 0x0000) when `RST_KNOWN` is 1.
- R2: A cycle with `load_en` high makes `cur_addr` equal `load_addr` after the next rising clock edge.
- R3: `load_en` takes priority: when it is high in the same cycle as `rd_adv` and/or `wr_adv`, the loaded value appears unchanged and no advance is applied.
- R4: `rd_adv` alone (no load) makes the next `cur_addr` equal the current value plus one modulo 65536, carrying across page boundaries (0x007F becomes 0x0080).
- R5: A read advance from 0xFFFF gives 0x0000.
- R6: `wr_adv` (no load) increments only the low 7 bits (page offset) modulo 128 and keeps the upper 9 bits unchanged: 0x12FF becomes 0x1280 and 0xFFFF becomes 0xFF80.
- R7: A write advance inside a page gives the current value plus one (0x1234 becomes 0x1235).
- R8: With no strobe high, `cur_addr` holds its value.
- R9: If `rd_adv` and `wr_adv` are both high without a load, the write (page-local) rule applies: 0x00FF becomes 0x0080.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Load strobe for a header address |
| load_addr | input | 16 | Address assembled from the two header bytes |
| rd_adv | input | 1 | Advance after a byte has been read |
| wr_adv | input | 1 | Advance after a byte has been written |
| cur_addr | output | 16 | Current location register |

## Verification
A wrong internal state here has no buffer to hide in. `cur_addr` is the register itself, so any fault shows at the port one clock edge after the strobe that caused it. The most likely faults are a carry that leaks out of the page field on a write, a read that stops or wraps at a page boundary, and a lost load priority. The cases that separate them are the page-end and array-end values, and combined strobes in the same cycle. Each of these is sampled on the cycle after its strobe.

// File: rtl/addr_ptr_pkg.sv
package addr_ptr_pkg;
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_LOAD = 2'd1,
      STEP_RD   = 2'd2,
      STEP_WR   = 2'd3
   } step_e;
endpackage

// File: rtl/addr_ptr_next.sv
module addr_ptr_next #(
   parameter int ADDR_W = 16,
   parameter int PAGE_W = 7
) (
   input  logic [ADDR_W-1:0] cur,
   output logic [ADDR_W-1:0] nxt_rd,
   output logic [ADDR_W-1:0] nxt_wr
);
   localparam int UPPER_W = ADDR_W - PAGE_W;

   // full-array increment, wraps at the top of the address space
   assign nxt_rd = cur + ADDR_W'(1);

   // page-local increment: carry is confined to the offset field
   generate
      if (UPPER_W > 0) begin : g_paged
         logic [PAGE_W-1:0] off_inc;
         assign off_inc = cur[PAGE_W-1:0] + PAGE_W'(1);
         assign nxt_wr  = {cur[ADDR_W-1:PAGE_W], off_inc};
      end else begin : g_flat
         assign nxt_wr = cur + ADDR_W'(1);
      end
   endgenerate
endmodule

// File: rtl/addr_ptr_reg.sv
module addr_ptr_reg
   import addr_ptr_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter bit          RST_KNOWN = 1'b1,
   parameter logic [ADDR_W-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  step_e             step,
   input  logic [ADDR_W-1:0] ld_val,
   input  logic [ADDR_W-1:0] rd_val,
   input  logic [ADDR_W-1:0] wr_val,
   output logic [ADDR_W-1:0] q
);
   logic [ADDR_W-1:0] d;

   always_comb begin
      unique case (step)
         STEP_LOAD: d = ld_val;
         STEP_RD:   d = rd_val;
         STEP_WR:   d = wr_val;
         default:   d = q;
      endcase
   end

   generate
      if (RST_KNOWN) begin : g_rst_known
         always_ff @(posedge clk) begin
            if (!rst_n) q <= RST_VAL;
            else        q <= d;
         end
      end else begin : g_rst_unknown
         // models undefined power-up content
         always_ff @(posedge clk) begin
            if (!rst_n) q <= 'x;
            else        q <= d;
         end
      end
   endgenerate
endmodule

// File: rtl/mem_addr_ptr.sv
module mem_addr_ptr
   import addr_ptr_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          PAGE_W    = 7,
   parameter bit          RST_KNOWN = 1'b1,
   parameter logic [ADDR_W-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              rd_adv,
   input  logic              wr_adv,
   output logic [ADDR_W-1:0] cur_addr
);
   localparam int UPPER_W = ADDR_W - PAGE_W;

   generate
      if (PAGE_W < 1 || PAGE_W > ADDR_W) begin : g_bad_page
         $error("mem_addr_ptr: PAGE_W must lie in 1..ADDR_W");
      end
   endgenerate

   logic [ADDR_W-1:0] nxt_rd, nxt_wr;
   step_e             step;

   // load first, then write rule, then read rule
   always_comb begin
      if (load_en)     step = STEP_LOAD;
      else if (wr_adv) step = STEP_WR;
      else if (rd_adv) step = STEP_RD;
      else             step = STEP_HOLD;
   end

   addr_ptr_next #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_next (
      .cur    (cur_addr),
      .nxt_rd (nxt_rd),
      .nxt_wr (nxt_wr)
   );

   addr_ptr_reg #(.ADDR_W(ADDR_W), .RST_KNOWN(RST_KNOWN), .RST_VAL(RST_VAL)) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (step),
      .ld_val (load_addr),
      .rd_val (nxt_rd),
      .wr_val (nxt_wr),
      .q      (cur_addr)
   );

   // R2 R3
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> cur_addr == $past(load_addr));

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && !rd_adv && !wr_adv) |=> $stable(cur_addr));

   // R4 R5
   rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && !wr_adv && rd_adv) |=> cur_addr == $past(cur_addr) + ADDR_W'(1));

   // R6 R9
   generate
      if (UPPER_W > 0) begin : g_wr_chk
         wr_page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!load_en && wr_adv) |=> $stable(cur_addr[ADDR_W-1:PAGE_W]));
      end
   endgenerate
endmodule

// File: tb/sim_mem_addr_ptr.sv
module sim_mem_addr_ptr;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_en = 1'b0;
   logic [15:0] load_addr = '0;
   logic        rd_adv = 1'b0;
   logic        wr_adv = 1'b0;
   logic [15:0] cur_addr;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   mem_addr_ptr u0 (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
      .rd_adv(rd_adv), .wr_adv(wr_adv), .cur_addr(cur_addr)
   );

   // vector: {ld, rd, wr, value[15:0], expected[15:0]}
   localparam int NV = 17;
   localparam logic [34:0] VEC [NV] = '{
      {3'b100, 16'h1234, 16'h1234},   // R2
      {3'b001, 16'h0000, 16'h1235},   // R7
      {3'b100, 16'h12FE, 16'h12FE},   // R2
      {3'b001, 16'h0000, 16'h12FF},   // R7
      {3'b001, 16'h0000, 16'h1280},   // R6 page wrap
      {3'b010, 16'h0000, 16'h1281},   // R4
      {3'b100, 16'h007F, 16'h007F},   // R2
      {3'b010, 16'h0000, 16'h0080},   // R4 crosses page
      {3'b100, 16'hFFFF, 16'hFFFF},   // R2
      {3'b010, 16'h0000, 16'h0000},   // R5 array wrap
      {3'b010, 16'h0000, 16'h0001},   // R4
      {3'b000, 16'hAAAA, 16'h0001},   // R8 hold
      {3'b111, 16'h5555, 16'h5555},   // R3 load beats both advances
      {3'b100, 16'h00FF, 16'h00FF},   // R2
      {3'b011, 16'h0000, 16'h0080},   // R9 write rule wins
      {3'b100, 16'hFFFF, 16'hFFFF},   // R2
      {3'b001, 16'h0000, 16'hFF80}    // R6 top page wraps in place
   };

   task automatic check(input string req, input logic [15:0] exp);
      checks++;
      if (cur_addr !== exp) begin
         fails++;
         $display("FAIL %s: cur_addr=%h expected=%h", req, cur_addr, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #4_000_000;
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 in reset", 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", 16'h0000);

      for (int i = 0; i < NV; i++) begin
         {load_en, rd_adv, wr_adv} = VEC[i][34:32];
         load_addr = VEC[i][31:16];
         @(negedge clk);
         check($sformatf("vector %0d", i), VEC[i][15:0]);
      end
      {load_en, rd_adv, wr_adv} = 3'b000;

      // R8 several idle cycles
      repeat (4) @(negedge clk);
      check("R8 long hold", 16'hFF80);

      // R4 R5 sequential read burst through the array end
      load_en = 1'b1; load_addr = 16'hFFFD;
      @(negedge clk);
      load_en = 1'b0; rd_adv = 1'b1;
      repeat (5) @(negedge clk);
      rd_adv = 1'b0;
      check("R5 burst through top", 16'h0002);

      // R6 full page write burst returns to start offset
      load_en = 1'b1; load_addr = 16'h3A45;
      @(negedge clk);
      load_en = 1'b0; wr_adv = 1'b1;
      repeat (128) @(negedge clk);
      wr_adv = 1'b0;
      check("R6 128 writes return", 16'h3A45);

      // R1 reset mid-run
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset mid-run", 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 held after reset", 16'h0000);

      finish_run();
   end
endmodule